// File: doc/BRIEF.md
# Register Write-Pending Scoreboard

This block keeps one pending flag per architectural register of a register file. A raised flag means some execution unit has been issued an instruction that will write that register and the result has not yet arrived. Each execution unit reports its issue (with its destination and whether it writes at all), its busy state and its completion. The register file write ports report each granted writeback. Several units and several write ports can raise and lower flags in the same cycle. Their requests are OR-merged into one set vector and one clear vector.

Consumers use the vector in two ways. Each read-check port tests one source register against the registered vector and reports a read-after-write hazard. One issue-side check tests the destination of the incoming instruction against the bypassed vector and reports a write-after-write hazard. The bypassed vector is the registered value with this cycle's clears and sets already applied.

Register numbers are binary indexes or one-hot vectors, chosen by a parameter. The issue-time set is held back one cycle. Because of this, an instruction that reads and writes the same register does not see a hazard on itself.

Top module: `wpend_scoreboard`

## Requirements
- R1: After reset the registered vector `pend_q` is all zeros. In a cycle with no set and no clear request, `pend_q` keeps its value across the next clock edge.
- R2: A unit that issues with its write flag high, at clock edge t, raises its destination bit in `pend_nx` during the cycle after edge t, and in `pend_q` after edge t+1. A read check of that register in the issue cycle itself reports no hazard.
- R3: A write port that fires clears its register's bit in `pend_nx` in the same cycle, and in `pend_q` after the next edge.
- R4: Set requests from all units, and clear requests from all write ports and from all no-write completions, are OR-merged. Every request in a cycle takes effect.
- R5: Each unit captures its write flag and destination when it issues, and drops the captured flag in any cycle in which it is not busy and not issuing. When the unit signals done while the captured flag is set and its write-valid bit is low, the captured destination is cleared like a writeback. After the flag has been dropped, a done clears nothing.
- R6: `rd_hazard[i]` is high when read port i is active, its read flag is set, its check is not disabled (R7), and the `pend_q` bit of its source register is set.
- R7: Once a read port's check is enabled while its unit is busy and no hazard is seen, the check is disabled and the hazard stays low until `rd_active[i]` goes low.
- R8: `waw_hazard` is high when `new_wr` is high and the `pend_nx` bit of `new_dst` is set.
- R9: When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: With ENC = ENC_BINARY, register number b selects bit b of the vector. With ENC = ENC_ONEHOT, the input vector is used as the mask directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| u_issue | input | NUNIT | Unit issue strobe, one bit per unit |
| u_wrflag | input | NUNIT | Issued instruction writes a register |
| u_dst | input | NUNIT*RW | Destination register number per unit |
| u_busy | input | NUNIT | Unit busy |
| u_done | input | NUNIT | Unit completes in this cycle |
| u_wrok | input | NUNIT | Unit's result is valid for writeback |
| wb_fire | input | NWB | Write port granted and writing |
| wb_dst | input | NWB*RW | Register number written per port |
| rd_active | input | NRD | Consumer of read port is active |
| rd_flag | input | NRD | Operand is actually read |
| rd_busy | input | NRD | Consumer's unit is busy |
| rd_src | input | NRD*RW | Source register number per read port |
| new_wr | input | 1 | Incoming instruction writes a register |
| new_dst | input | RW | Destination of the incoming instruction |
| pend_q | output | NREG | Registered pending vector |
| pend_nx | output | NREG | Bypassed pending vector |
| rd_hazard | output | NRD | Read-after-write hazard per read port |
| waw_hazard | output | 1 | Write-after-write hazard on the incoming destination |

## Verification
The assertions assume that a one-hot register number has at most one bit set, and that a binary number stays below NREG. The bench drives binary numbers drawn only in range. They also assume that a unit does not issue and complete on the same edge in a way that conflicts with its own captured destination. The bench's behavioural model follows the same rule for that case, so random overlaps stay consistent with it. The directed phase reaches the corner cases: self-dependency at issue, a set colliding with a clear, a no-write completion before and after the captured flag drops, and the read-check disable. A random phase then mixes all request sources against the model.

// File: rtl/wps_pkg.sv
package wps_pkg;
   typedef enum logic {ENC_BINARY = 1'b0, ENC_ONEHOT = 1'b1} enc_e;

   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/wps_decode.sv
module wps_decode
   import wps_pkg::*;
#(
   parameter int   NREG = 32,
   parameter enc_e ENC  = ENC_BINARY,
   parameter int   RW   = idx_w(NREG)
) (
   input  logic            en,
   input  logic [RW-1:0]   code,
   output logic [NREG-1:0] mask
);
   generate
      if (ENC == ENC_ONEHOT) begin : g_unary
         if (RW != NREG) begin : g_bad_w
            $error("one-hot code width must equal NREG");
         end
         always_comb mask = en ? NREG'(code) : '0;
      end else begin : g_binary
         localparam logic [NREG-1:0] ONE = {{(NREG-1){1'b0}}, 1'b1};
         always_comb mask = en ? (ONE << code) : '0;
      end
   endgenerate
endmodule

// File: rtl/wps_unit_track.sv
module wps_unit_track
   import wps_pkg::*;
#(
   parameter int   NREG = 32,
   parameter enc_e ENC  = ENC_BINARY,
   parameter int   RW   = idx_w(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue,
   input  logic            wrflag,
   input  logic [RW-1:0]   dst,
   input  logic            busy,
   input  logic            done,
   input  logic            wrok,
   output logic [NREG-1:0] set_mask,
   output logic [NREG-1:0] nowr_clr
);
   logic          lat_wr;
   logic [RW-1:0] lat_dst;
   logic          set_en;
   logic          nowr_en;

   assign set_en  = issue & wrflag;
   assign nowr_en = done & lat_wr & ~wrok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_wr  <= 1'b0;
         lat_dst <= '0;
      end else if (issue) begin
         lat_wr  <= wrflag;
         lat_dst <= dst;
      end else if (!busy) begin
         lat_wr  <= 1'b0;
      end
   end

   wps_decode #(.NREG(NREG), .ENC(ENC), .RW(RW)) u_set_dec (
      .en(set_en), .code(dst), .mask(set_mask));

   wps_decode #(.NREG(NREG), .ENC(ENC), .RW(RW)) u_clr_dec (
      .en(nowr_en), .code(lat_dst), .mask(nowr_clr));

   AST_FLAG_DROPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !issue) |=> !lat_wr); // R5
   AST_NOWR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (nowr_clr != '0) |-> (lat_wr && done && !wrok)); // R5
endmodule

// File: rtl/wps_rd_check.sv
module wps_rd_check
   import wps_pkg::*;
#(
   parameter int   NREG = 32,
   parameter enc_e ENC  = ENC_BINARY,
   parameter int   RW   = idx_w(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            rdflag,
   input  logic            busy,
   input  logic [RW-1:0]   src,
   input  logic [NREG-1:0] vec,
   output logic            hazard
);
   logic            passed;
   logic            chk_en;
   logic [NREG-1:0] chk_mask;

   assign chk_en = active & rdflag & ~passed;

   wps_decode #(.NREG(NREG), .ENC(ENC), .RW(RW)) u_src_dec (
      .en(chk_en), .code(src), .mask(chk_mask));

   assign hazard = |(vec & chk_mask);

   always_ff @(posedge clk) begin
      if (!rst_n)                          passed <= 1'b0;
      else if (!active)                    passed <= 1'b0;
      else if (chk_en && busy && !hazard)  passed <= 1'b1;
   end

   AST_MASK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chk_mask)); // R6
   AST_PASSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      passed |-> !hazard); // R7
   AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !hazard); // R6
endmodule

// File: rtl/wpend_scoreboard.sv
module wpend_scoreboard
   import wps_pkg::*;
#(
   parameter int   NREG  = 32,
   parameter int   NUNIT = 4,
   parameter int   NWB   = 2,
   parameter int   NRD   = 3,
   parameter enc_e ENC   = ENC_BINARY,
   parameter int   RW    = (ENC == ENC_ONEHOT) ? NREG : idx_w(NREG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUNIT-1:0]    u_issue,
   input  logic [NUNIT-1:0]    u_wrflag,
   input  logic [NUNIT*RW-1:0] u_dst,
   input  logic [NUNIT-1:0]    u_busy,
   input  logic [NUNIT-1:0]    u_done,
   input  logic [NUNIT-1:0]    u_wrok,
   input  logic [NWB-1:0]      wb_fire,
   input  logic [NWB*RW-1:0]   wb_dst,
   input  logic [NRD-1:0]      rd_active,
   input  logic [NRD-1:0]      rd_flag,
   input  logic [NRD-1:0]      rd_busy,
   input  logic [NRD*RW-1:0]   rd_src,
   input  logic                new_wr,
   input  logic [RW-1:0]       new_dst,
   output logic [NREG-1:0]     pend_q,
   output logic [NREG-1:0]     pend_nx,
   output logic [NRD-1:0]      rd_hazard,
   output logic                waw_hazard
);
   generate
      if (NREG < 2)  begin : g_bad_nreg  $error("NREG must be at least 2");  end
      if (NUNIT < 1) begin : g_bad_nunit $error("NUNIT must be at least 1"); end
      if (NWB < 1)   begin : g_bad_nwb   $error("NWB must be at least 1");   end
      if (NRD < 1)   begin : g_bad_nrd   $error("NRD must be at least 1");   end
   endgenerate

   logic [NREG-1:0] unit_set [NUNIT];
   logic [NREG-1:0] unit_clr [NUNIT];
   logic [NREG-1:0] wb_mask  [NWB];
   logic [NREG-1:0] set_req;
   logic [NREG-1:0] set_dly;
   logic [NREG-1:0] clr_all;
   logic [NREG-1:0] waw_mask;

   genvar gi;
   generate
      for (gi = 0; gi < NUNIT; gi++) begin : g_unit
         wps_unit_track #(.NREG(NREG), .ENC(ENC), .RW(RW)) u_track (
            .clk(clk), .rst_n(rst_n),
            .issue(u_issue[gi]), .wrflag(u_wrflag[gi]),
            .dst(u_dst[gi*RW +: RW]),
            .busy(u_busy[gi]), .done(u_done[gi]), .wrok(u_wrok[gi]),
            .set_mask(unit_set[gi]), .nowr_clr(unit_clr[gi]));
      end
      for (gi = 0; gi < NWB; gi++) begin : g_wb
         wps_decode #(.NREG(NREG), .ENC(ENC), .RW(RW)) u_wb_dec (
            .en(wb_fire[gi]), .code(wb_dst[gi*RW +: RW]), .mask(wb_mask[gi]));
      end
      for (gi = 0; gi < NRD; gi++) begin : g_rd
         wps_rd_check #(.NREG(NREG), .ENC(ENC), .RW(RW)) u_chk (
            .clk(clk), .rst_n(rst_n),
            .active(rd_active[gi]), .rdflag(rd_flag[gi]), .busy(rd_busy[gi]),
            .src(rd_src[gi*RW +: RW]), .vec(pend_q), .hazard(rd_hazard[gi]));
      end
   endgenerate

   always_comb begin
      set_req = '0;
      clr_all = '0;
      for (int i = 0; i < NUNIT; i++) begin
         set_req = set_req | unit_set[i];
         clr_all = clr_all | unit_clr[i];
      end
      for (int i = 0; i < NWB; i++) clr_all = clr_all | wb_mask[i];
   end

   assign pend_nx = (pend_q & ~clr_all) | set_dly;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         set_dly <= '0;
         pend_q  <= '0;
      end else begin
         set_dly <= set_req;
         pend_q  <= pend_nx;
      end
   end

   wps_decode #(.NREG(NREG), .ENC(ENC), .RW(RW)) u_waw_dec (
      .en(new_wr), .code(new_dst), .mask(waw_mask));

   assign waw_hazard = |(pend_nx & waw_mask);

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (set_dly == '0 && clr_all == '0) |=> $stable(pend_q)); // R1
   AST_SET_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req != '0) |=> ((pend_nx & $past(set_req)) == $past(set_req))); // R2
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_all & ~set_dly) != '0) |=> ((pend_q & $past(clr_all & ~set_dly)) == '0)); // R3
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_dly & clr_all) != '0) |=> ((pend_q & $past(set_dly & clr_all)) == $past(set_dly & clr_all))); // R9
   AST_WAW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !new_wr |-> !waw_hazard); // R8
endmodule

// File: tb/wpend_scoreboard_test.sv
module wpend_scoreboard_test;
   import wps_pkg::*;
   localparam int N  = 16;
   localparam int NU = 3;
   localparam int NW = 2;
   localparam int NR = 2;
   localparam int RW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NU-1:0] u_issue, u_wrflag, u_busy, u_done, u_wrok;
   logic [NU*RW-1:0] u_dst;
   logic [NW-1:0] wb_fire;
   logic [NW*RW-1:0] wb_dst;
   logic [NR-1:0] rd_active, rd_flag, rd_busy;
   logic [NR*RW-1:0] rd_src;
   logic new_wr;
   logic [RW-1:0] new_dst;
   logic [N-1:0] pend_q, pend_nx;
   logic [NR-1:0] rd_hazard;
   logic waw_hazard;

   int n_chk = 0;
   int n_err = 0;

   // behavioural reference state
   bit [N-1:0] m_q, m_setd;
   bit m_lw [NU];
   int m_ld [NU];
   bit m_pass [NR];

   always #5 clk = ~clk;

   wpend_scoreboard #(.NREG(N), .NUNIT(NU), .NWB(NW), .NRD(NR), .ENC(ENC_BINARY)) uut (
      .clk(clk), .rst_n(rst_n), .u_issue(u_issue), .u_wrflag(u_wrflag), .u_dst(u_dst),
      .u_busy(u_busy), .u_done(u_done), .u_wrok(u_wrok), .wb_fire(wb_fire), .wb_dst(wb_dst),
      .rd_active(rd_active), .rd_flag(rd_flag), .rd_busy(rd_busy), .rd_src(rd_src),
      .new_wr(new_wr), .new_dst(new_dst), .pend_q(pend_q), .pend_nx(pend_nx),
      .rd_hazard(rd_hazard), .waw_hazard(waw_hazard));

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      u_issue = '0; u_wrflag = '0; u_dst = '0; u_busy = '0; u_done = '0; u_wrok = '0;
      wb_fire = '0; wb_dst = '0; rd_active = '0; rd_flag = '0; rd_busy = '0;
      rd_src = '0; new_wr = 1'b0; new_dst = '0;
   endtask

   task automatic unit(input int i, input bit iss, input bit wf, input int d,
                       input bit bsy, input bit dn, input bit ok);
      u_issue[i] = iss; u_wrflag[i] = wf; u_dst[i*RW +: RW] = RW'(d);
      u_busy[i] = bsy; u_done[i] = dn; u_wrok[i] = ok;
   endtask

   task automatic wb(input int p, input bit f, input int d);
      wb_fire[p] = f; wb_dst[p*RW +: RW] = RW'(d);
   endtask

   task automatic rd(input int p, input bit a, input bit f, input bit b, input int s);
      rd_active[p] = a; rd_flag[p] = f; rd_busy[p] = b; rd_src[p*RW +: RW] = RW'(s);
   endtask

   // one cycle: inputs already driven after a falling edge
   task automatic cyc(input string tag);
      bit [N-1:0] clr, nx, sn;
      bit [NR-1:0] eh;
      bit ew;
      bit en;
      #4;
      clr = '0;
      for (int p = 0; p < NW; p++)
         if (wb_fire[p]) clr[int'(wb_dst[p*RW +: RW])] = 1'b1;
      for (int i = 0; i < NU; i++)
         if (u_done[i] && m_lw[i] && !u_wrok[i]) clr[m_ld[i]] = 1'b1;
      nx = (m_q & ~clr) | m_setd;
      for (int p = 0; p < NR; p++) begin
         en = rd_active[p] && rd_flag[p] && !m_pass[p];
         eh[p] = en && m_q[int'(rd_src[p*RW +: RW])];
      end
      ew = new_wr && nx[int'(new_dst)];
      chk(pend_q == m_q, tag, "pend_q", 32'(pend_q), 32'(m_q));
      chk(pend_nx == nx, tag, "pend_nx", 32'(pend_nx), 32'(nx));
      chk(rd_hazard == eh, tag, "rd_hazard", 32'(rd_hazard), 32'(eh));
      chk(waw_hazard == ew, tag, "waw_hazard", 32'(waw_hazard), 32'(ew));
      sn = '0;
      for (int i = 0; i < NU; i++)
         if (u_issue[i] && u_wrflag[i]) sn[int'(u_dst[i*RW +: RW])] = 1'b1;
      @(posedge clk);
      m_q = nx;
      m_setd = sn;
      for (int i = 0; i < NU; i++) begin
         if (u_issue[i]) begin m_lw[i] = u_wrflag[i]; m_ld[i] = int'(u_dst[i*RW +: RW]); end
         else if (!u_busy[i]) m_lw[i] = 1'b0;
      end
      for (int p = 0; p < NR; p++) begin
         if (!rd_active[p]) m_pass[p] = 1'b0;
         else if (rd_active[p] && rd_flag[p] && !m_pass[p] && rd_busy[p] && !eh[p]) m_pass[p] = 1'b1;
      end
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      m_q = '0; m_setd = '0;
      for (int i = 0; i < NU; i++) begin m_lw[i] = 0; m_ld[i] = 0; end
      for (int p = 0; p < NR; p++) m_pass[p] = 0;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc("R1");                               // reset state is all zero
      cyc("R1");                               // quiet cycle holds
      // R2 / R10: issue to r5, same instruction reads r5 at issue
      unit(0, 1, 1, 5, 0, 0, 0); rd(0, 1, 1, 0, 5);
      cyc("R2");
      idle(); unit(0, 0, 0, 0, 1, 0, 0); rd(1, 1, 1, 0, 5);
      cyc("R2");                               // bypass shows bit 5, registered not yet
      cyc("R6");                               // dependent read now hazards (bit 5 = r5, R10)
      // R3 / R4: two write ports clear in one cycle
      wb(0, 1, 5); wb(1, 1, 7);
      cyc("R3");
      idle(); cyc("R3");
      // R4: two units set together
      unit(1, 1, 1, 9, 0, 0, 0); unit(2, 1, 1, 3, 0, 0, 0);
      cyc("R4");
      idle(); unit(1, 0, 0, 0, 1, 0, 0); unit(2, 0, 0, 0, 1, 0, 0);
      cyc("R4"); cyc("R4");
      // R5: unit1 done without write clears r9; unit2 done with write keeps r3
      unit(1, 0, 0, 0, 1, 1, 0); unit(2, 0, 0, 0, 1, 1, 1);
      cyc("R5");
      idle(); cyc("R5");
      wb(0, 1, 3); cyc("R4");
      idle(); cyc("R5");                       // unit2 idle: captured flag drops
      unit(0, 1, 1, 3, 0, 0, 0); cyc("R5");
      idle(); cyc("R5"); cyc("R5");
      unit(2, 0, 0, 0, 0, 1, 0); cyc("R5");    // stale done must not clear r3
      idle(); cyc("R5");
      // R9: set and clear of r11 collide
      unit(0, 1, 1, 11, 0, 0, 0); cyc("R9");
      idle(); wb(0, 1, 11); cyc("R9");
      idle(); cyc("R9");
      // R8: write-after-write against the bypassed view
      new_wr = 1; new_dst = 11; cyc("R8");
      new_dst = 12; cyc("R8");
      idle(); wb(0, 1, 11); wb(1, 1, 3); cyc("R8");
      idle(); cyc("R8");
      // R7: read check disabled after a clean busy cycle
      rd(0, 1, 1, 1, 12); cyc("R7");
      unit(1, 1, 1, 12, 0, 0, 0); cyc("R7");
      unit(1, 0, 0, 0, 1, 0, 0); cyc("R7"); cyc("R7"); cyc("R7");
      rd(0, 0, 0, 0, 12); cyc("R7");
      rd(0, 1, 1, 0, 12); cyc("R6");           // re-armed check sees r12
      idle(); wb(0, 1, 12); cyc("R3");
      idle(); cyc("R1");
      // random mix against the model (R4 and all others)
      for (int k = 0; k < 600; k++) begin
         idle();
         for (int i = 0; i < NU; i++)
            unit(i, ($urandom_range(0, 3) == 0), $urandom_range(0, 1), $urandom_range(0, N - 1),
                 $urandom_range(0, 1), ($urandom_range(0, 3) == 0), $urandom_range(0, 1));
         for (int p = 0; p < NW; p++) wb(p, ($urandom_range(0, 2) == 0), $urandom_range(0, N - 1));
         for (int p = 0; p < NR; p++)
            rd(p, ($urandom_range(0, 3) != 0), $urandom_range(0, 1), $urandom_range(0, 1),
               $urandom_range(0, N - 1));
         new_wr = $urandom_range(0, 1); new_dst = RW'($urandom_range(0, N - 1));
         cyc("R4");
      end
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule